// File: doc/BRIEF.md
# Byte-Serial Register Write Deserializer

This block sits between an 8-bit byte-serial command stream and a set of local registers. Each command is a short burst of bytes on consecutive clocks. The first byte is flagged by a strobe. The block collects a 16-bit register address and a fixed number of data bytes, then presents the address and a 32-bit data word with a one-clock write enable.

Many instances can share one stream. Each instance compares the upper address bits against its own base address under a mask. It answers only to commands that fall inside its window, and it hands on just the offset inside that window. A strobe that arrives while a command is still being collected drops the partial command and starts a new one.

Top module: `cmd_deser`

## Requirements
- R1: A command is two address bytes and then DATA_BYTES data bytes, one byte per clock. The address low byte comes first, then the address high byte. Data follows least significant byte first, so data byte k lands in wr_data bits [8k+7:8k]. Data bits above the last configured byte read 0.
- R2: When a command is accepted, wr_en is high for exactly one clock. That clock is the one that follows the clock carrying the last byte. With the strobe in cycle t, the pulse is in cycle t+2+DATA_BYTES.
- R3: Bytes that arrive while no command is open, without the strobe, are ignored: they produce no pulse and leave wr_addr and wr_data unchanged.
- R4: A strobe during a partly collected command discards that command and starts a new one with the current byte as its address low byte. Only the new command can produce a pulse.
- R5: A command is accepted only when (address & ADDR_MASK) == (BASE_ADDR & ADDR_MASK). Any other command produces no pulse and leaves the outputs unchanged.
- R6: wr_addr carries the local offset, address & ~ADDR_MASK. With the defaults (BASE_ADDR 16'h0700, ADDR_MASK 16'hFFF8), address 16'h0705 gives wr_addr 5.
- R7: The asynchronous active-low reset clears wr_en, wr_addr and wr_data to 0 and discards any partial command. Bytes that arrive after reset without a new strobe produce no pulse.
- R8: wr_addr and wr_data change only in the cycle in which wr_en is high, and they hold their values between pulses.
- R9: Commands sent back to back, each strobe in the clock right after the previous command's last byte, each produce their own pulse with their own address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cmd_byte | input | 8 | Command byte stream |
| cmd_first | input | 1 | High with the first byte (address low) of a command |
| wr_en | output | 1 | One-clock write enable |
| wr_addr | output | 16 | Local register offset inside the window |
| wr_data | output | 32 | Assembled write data |

## Verification
Suppose the byte counter slips or fails to restart on a strobe. Then the first wrong pulse is misplaced by a clock, or a pulse is missing, or the address and data bytes are shuffled into the wrong lanes. All of these show up at the next command boundary, within 2+DATA_BYTES clocks. A wrong lane register shows up in the value of wr_addr or wr_data in that same pulse cycle. A wrong window compare shows up as a missing pulse or an extra pulse for a miss command. It also shows up as outputs that change without wr_en.

// File: rtl/cmd_deser_pkg.sv
package cmd_deser_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cmd_deser_seq.sv
// Byte position tracker: where in the command the current byte sits.
module cmd_deser_seq #(
  parameter int NBYTES = 6,
  localparam int IDX_W = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first,
  output logic             valid,
  output logic [IDX_W-1:0] pos,
  output logic             last
);
  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    valid = first | active_q;
    pos   = first ? '0 : idx_q;
    last  = valid && (pos == IDX_W'(NBYTES - 1));
  end

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    if (first) begin
      active_d = 1'b1;
      idx_d    = IDX_W'(1);
    end else if (active_q) begin
      if (idx_q == IDX_W'(NBYTES - 1)) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  // R4: a strobe always restarts collection at the second byte position
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    first |=> (active_q && idx_q == IDX_W'(1)));
  // R3: an open command never points past its last byte or at byte 0
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (idx_q != '0 && idx_q < IDX_W'(NBYTES)));
endmodule

// File: rtl/cmd_deser_asm.sv
// Byte lanes: each lane latches the byte that arrives at its position.
module cmd_deser_asm
  import cmd_deser_pkg::*;
#(
  parameter int NBYTES = 6,
  localparam int IDX_W  = $clog2(NBYTES + 1),
  localparam int VIEW_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  byte_t             byte_in,
  input  logic              valid,
  input  logic [IDX_W-1:0]  pos,
  output logic [VIEW_W-1:0] view
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    byte_t lane_q;
    logic  take;
    always_comb take = valid && (pos == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lane_q <= '0;
      else if (take) lane_q <= byte_in;
    end
    always_comb view[g*BYTE_W +: BYTE_W] = take ? byte_in : lane_q;
  end
endmodule

// File: rtl/cmd_deser_out.sv
// Window compare and output registers.
module cmd_deser_out
  import cmd_deser_pkg::*;
#(
  parameter int           NBYTES     = 6,
  parameter int           DATA_BYTES = 4,
  parameter logic [15:0]  BASE_ADDR  = 16'h0700,
  parameter logic [15:0]  ADDR_MASK  = 16'hFFF8,
  localparam int VIEW_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VIEW_W-1:0] view,
  input  logic              last,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [ADDR_W-1:0] full_addr;
  logic [DATA_W-1:0] data_w;
  logic              hit, load;
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_comb full_addr = view[ADDR_W-1:0];

  if (DATA_BYTES == 0) begin : g_nodata
    always_comb data_w = '0;
  end else begin : g_data
    always_comb data_w = DATA_W'(view[VIEW_W-1:ADDR_W]);
  end

  always_comb begin
    hit  = (full_addr & ADDR_MASK) == (BASE_ADDR & ADDR_MASK);
    load = last && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      en_q <= load;
      if (load) begin
        addr_q <= full_addr & ~ADDR_MASK;
        data_q <= data_w;
      end
    end
  end

  always_comb begin
    wr_en   = en_q;
    wr_addr = addr_q;
    wr_data = data_q;
  end

  // R2: the write enable never lasts more than one clock
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> !en_q);
  // R5: a completed command outside the window gives no pulse
  a_r5_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !hit) |=> !en_q);
  // R8: outputs hold whenever no pulse is shown
  a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/cmd_deser.sv
module cmd_deser
  import cmd_deser_pkg::*;
#(
  parameter int          DATA_BYTES = 4,
  parameter logic [15:0] BASE_ADDR  = 16'h0700,
  parameter logic [15:0] ADDR_MASK  = 16'hFFF8,
  localparam int NBYTES = ADDR_BYTES + DATA_BYTES,
  localparam int IDX_W  = $clog2(NBYTES + 1),
  localparam int VIEW_W = NBYTES * BYTE_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cmd_byte,
  input  logic        cmd_first,
  output logic        wr_en,
  output logic [15:0] wr_addr,
  output logic [31:0] wr_data
);
  logic              valid, last;
  logic [IDX_W-1:0]  pos;
  logic [VIEW_W-1:0] view;

  initial assert (DATA_BYTES >= 0 && DATA_BYTES <= 4);

  cmd_deser_seq #(.NBYTES(NBYTES)) seq_i (
    .clk(clk), .rst_n(rst_n), .first(cmd_first),
    .valid(valid), .pos(pos), .last(last));

  cmd_deser_asm #(.NBYTES(NBYTES)) asm_i (
    .clk(clk), .rst_n(rst_n), .byte_in(cmd_byte),
    .valid(valid), .pos(pos), .view(view));

  cmd_deser_out #(.NBYTES(NBYTES), .DATA_BYTES(DATA_BYTES),
                  .BASE_ADDR(BASE_ADDR), .ADDR_MASK(ADDR_MASK)) out_i (
    .clk(clk), .rst_n(rst_n), .view(view), .last(last),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));
endmodule

// File: tb/cmd_deser_tb.sv
module cmd_deser_tb_top;
  localparam int NB = 6;
  localparam logic [15:0] MASK = 16'hFFF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        cmd_first = 1'b0;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  int checks = 0;
  int fails = 0;

  cmd_deser dut_i (.clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte),
    .cmd_first(cmd_first), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [15:0] a, input logic [31:0] d, input int i);
    logic [47:0] w = {d, a};
    return w[i*8 +: 8];
  endfunction

  // drive bytes first..upto-1 of a command, one per negedge
  task automatic drive(input logic [15:0] a, input logic [31:0] d, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      @(negedge clk);
      cmd_byte  = byte_of(a, d, i);
      cmd_first = (i == 0);
      if (i > 0) chk("R2 no early pulse", wr_en, 0);
    end
  endtask

  task automatic idle;
    @(negedge clk);
    cmd_byte = 8'hA5; cmd_first = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R7 reset wr_en", wr_en, 0);
    chk("R7 reset wr_addr", wr_addr, 0);
    chk("R7 reset wr_data", wr_data, 0);
  endtask

  task automatic t_basic(input logic [15:0] a, input logic [31:0] d);
    drive(a, d, 0, NB);
    idle;
    chk("R2 pulse after last byte", wr_en, 1);
    chk("R1 R6 wr_addr", wr_addr, a & ~MASK);
    chk("R1 wr_data", wr_data, d);
    idle;
    chk("R2 one clock only", wr_en, 0);
  endtask

  task automatic t_ignore_idle;
    logic [15:0] a0 = wr_addr;
    logic [31:0] d0 = wr_data;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cmd_byte = 8'(i * 37 + 5); cmd_first = 1'b0;
      chk("R3 idle no pulse", wr_en, 0);
    end
    idle;
    chk("R3 R8 addr held", wr_addr, a0);
    chk("R3 R8 data held", wr_data, d0);
  endtask

  task automatic t_miss(input logic [15:0] a);
    logic [15:0] a0 = wr_addr;
    logic [31:0] d0 = wr_data;
    drive(a, 32'hCAFEF00D, 0, NB);
    idle; chk("R5 miss no pulse", wr_en, 0);
    idle; chk("R5 miss no pulse late", wr_en, 0);
    chk("R5 miss addr held", wr_addr, a0);
    chk("R5 miss data held", wr_data, d0);
  endtask

  task automatic t_restart;
    drive(16'h0701, 32'h11111111, 0, 3);
    drive(16'h0706, 32'h87654321, 0, NB);
    idle;
    chk("R4 restart pulse", wr_en, 1);
    chk("R4 restart addr", wr_addr, 16'h0006);
    chk("R4 restart data", wr_data, 32'h87654321);
    idle; chk("R4 single pulse", wr_en, 0);
  endtask

  task automatic t_back_to_back;
    drive(16'h0702, 32'h0A0B0C0D, 0, NB);
    drive(16'h0703, 32'hF0E0D0C0, 0, 1);
    chk("R9 first pulse", wr_en, 1);
    chk("R9 first addr", wr_addr, 16'h0002);
    chk("R9 first data", wr_data, 32'h0A0B0C0D);
    drive(16'h0703, 32'hF0E0D0C0, 1, NB);
    idle;
    chk("R9 second pulse", wr_en, 1);
    chk("R9 second addr", wr_addr, 16'h0003);
    chk("R9 second data", wr_data, 32'hF0E0D0C0);
    idle;
  endtask

  task automatic t_reset_mid;
    drive(16'h0704, 32'h55667788, 0, 3);
    #2 rst_n = 1'b0;
    #1 t_reset_state;
    @(negedge clk); rst_n = 1'b1;
    drive(16'h0704, 32'h55667788, 3, NB);
    idle; chk("R7 partial discarded", wr_en, 0);
    idle; chk("R7 partial discarded late", wr_en, 0);
    chk("R7 addr stays clear", wr_addr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state;
    rst_n = 1'b1;
    t_basic(16'h0705, 32'h12345678);
    t_basic(16'h0700, 32'hFFFFFFFF);
    t_basic(16'h0707, 32'h00000080);
    t_ignore_idle;
    t_miss(16'h0805);
    t_miss(16'h0F07);
    t_restart;
    t_back_to_back;
    t_reset_mid;
    t_basic(16'h0701, 32'hDEADBEEF);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule